// File: doc/BRIEF.md
# Instruction-Count Compare Timer

This block holds a free-running instruction counter and a 32-bit match value. The counter does not advance on clock cycles. Each cycle it adds the number of instructions that the core retired in that cycle, from zero to four. When an advance takes the low 32 bits of the counter from at or below the match value to at or above it, the block raises a timer request. This holds even when the advance skips over the match value. The request drives the timer bit of the core's pending-interrupt field.

Software reaches the counter and the match value through a register-style port with a write strobe, an address and write data. A combinational read returns the addressed register and a hit flag. Four addresses lead to the same counter: three of them are the usual cycle, time and instructions-retired aliases. The request is held in a two-state machine. In `REQ_IDLE` the request is low. The transition *fire* moves it to `REQ_PENDING` on a crossing. The transition *rearm* returns it to `REQ_IDLE` only when the match value is written. No other event lowers the request.

Top module: `insn_timer`

## Requirements
- R1: After reset the counter reads 0, the match value reads 32'hFFFF_FFFF and `timer_irq` is low.
- R2: In a cycle without a counter write, the counter grows by `retire_cnt`. Values of `retire_cnt` from 5 to 7 count as 4.
- R3: A write to address 12'hC00, 12'hC01, 12'hC02 or 12'h7C0 loads the same 64-bit counter. A read from any of these addresses returns the counter. Address 12'h7C1 is the match value: a write takes `csr_wdata[31:0]` and a read returns it zero-extended. Any other address reads 0 with `csr_hit` low, and a write to it changes nothing.
- R4: A counter write in the same cycle as a nonzero `retire_cnt` loads the written value, and the retire amount is dropped.
- R5: The request is set when the low 32 bits of the counter are ≤ the match value before an advance, and the low 32 bits plus the (clamped) retire amount are ≥ the match value. The sum is taken without wrap-around. `timer_irq` goes high at the clock edge that applies the advance. An advance that jumps past the match value also sets the request.
- R6: The comparison ignores counter bits 63:32.
- R7: No crossing is evaluated in a cycle that writes the counter.
- R8: A write to the match value loads it and clears the request at that edge. In the same cycle it overrides a crossing against the old match value.
- R9: Once set, the request stays high through counter rewrites, including rewrites below the match value, until the match value is written.
- R10: No request is raised when the low 32 bits start above the match value, even if the 32-bit sum wraps past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_cnt | input | 3 | Instructions retired this cycle |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data of the addressed register |
| csr_hit | output | 1 | Address matches a register of this block |
| timer_irq | output | 1 | Timer request level |

## Verification
Several properties hold on every cycle:
- The counter either takes the written value or grows by exactly the clamped retire amount.
- The request never drops without a match write, and never survives one.
- A rising request always follows a cycle in which the low counter bits were at or below the match value.

Only the directed scenarios can show the following:
- The address aliasing and the ignored addresses.
- The exact crossing point, including jumps past the match value.
- The wrap case that must stay silent.
- The masking of the high counter bits.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CYC   = 12'hC00;
    localparam logic [ADDR_W-1:0] A_TIME  = 12'hC01;
    localparam logic [ADDR_W-1:0] A_IRET  = 12'hC02;
    localparam logic [ADDR_W-1:0] A_COUNT = 12'h7C0;
    localparam logic [ADDR_W-1:0] A_MATCH = 12'h7C1;

    typedef enum logic [0:0] {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_e;

    typedef struct packed {
        logic cnt;
        logic match;
    } csr_sel_t;
endpackage

// File: rtl/tmr_csr_decode.sv
module tmr_csr_decode
    import timer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_t          sel
);
    always_comb begin
        sel = '0;
        unique case (addr)
            A_CYC, A_TIME, A_IRET, A_COUNT: sel.cnt   = 1'b1;
            A_MATCH:                        sel.match = 1'b1;
            default:                        sel       = '0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W   = 64,
    parameter int RET_W   = 3,
    parameter int MAX_RET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RET_W-1:0] retire,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [RET_W-1:0] step,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [RET_W-1:0] MAX_STEP = RET_W'(MAX_RET);

    always_comb begin
        step = (retire > MAX_STEP) ? MAX_STEP : retire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else begin
            count_q <= count_q + CNT_W'(step);
        end
    end

    // R4: a write wins over the retire amount
    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> count_q == $past(load_val));

    // R2: otherwise the counter grows by the clamped amount
    assert_step_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> count_q == $past(count_q) + CNT_W'($past(step)));
endmodule

// File: rtl/tmr_cross_detect.sv
module tmr_cross_detect #(
    parameter int CMP_W = 32,
    parameter int RET_W = 3,
    parameter logic [CMP_W-1:0] RESET_MATCH = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] count_low,
    input  logic [RET_W-1:0] step,
    input  logic             cnt_load,
    input  logic             match_we,
    input  logic [CMP_W-1:0] match_wdata,
    output logic [CMP_W-1:0] match_q,
    output logic             fire
);
    logic [CMP_W:0] sum_ext;
    logic           below_before;
    logic           reach_after;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= RESET_MATCH;
        end else if (match_we) begin
            match_q <= match_wdata;
        end
    end

    always_comb begin
        sum_ext      = {1'b0, count_low} + (CMP_W + 1)'(step);
        below_before = (count_low <= match_q);
        reach_after  = (sum_ext >= {1'b0, match_q});
        fire         = below_before && reach_after && !cnt_load && !match_we;
    end
endmodule

// File: rtl/tmr_req_fsm.sv
module tmr_req_fsm
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic rearm,
    output logic irq
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:    if (fire)  state_d = REQ_PENDING;
            REQ_PENDING: if (rearm) state_d = REQ_IDLE;
            default:     state_d = REQ_IDLE;
        endcase
        if (rearm) state_d = REQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == REQ_PENDING);
    end

    // R9: the request holds until the match value is written
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(rearm)) |-> irq);

    // R8: a match write always leaves the request low
    assert_rearm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rearm) |-> !irq);
endmodule

// File: rtl/insn_timer.sv
module insn_timer
    import timer_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int CMP_W   = 32,
    parameter int RET_W   = 3,
    parameter int MAX_RET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RET_W-1:0]  retire_cnt,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [CNT_W-1:0]  csr_wdata,
    output logic [CNT_W-1:0]  csr_rdata,
    output logic              csr_hit,
    output logic              timer_irq
);
    localparam int PAD_W = CNT_W - CMP_W;

    csr_sel_t         sel;
    logic             cnt_load;
    logic             match_we;
    logic [RET_W-1:0] step;
    logic [CNT_W-1:0] count_q;
    logic [CMP_W-1:0] match_q;
    logic             fire;

    tmr_csr_decode u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    always_comb begin
        cnt_load = csr_we && sel.cnt;
        match_we = csr_we && sel.match;
    end

    tmr_counter #(
        .CNT_W   (CNT_W),
        .RET_W   (RET_W),
        .MAX_RET (MAX_RET)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .retire   (retire_cnt),
        .load     (cnt_load),
        .load_val (csr_wdata),
        .step     (step),
        .count_q  (count_q)
    );

    tmr_cross_detect #(
        .CMP_W (CMP_W),
        .RET_W (RET_W)
    ) u_cross (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_low   (count_q[CMP_W-1:0]),
        .step        (step),
        .cnt_load    (cnt_load),
        .match_we    (match_we),
        .match_wdata (csr_wdata[CMP_W-1:0]),
        .match_q     (match_q),
        .fire        (fire)
    );

    tmr_req_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .rearm (match_we),
        .irq   (timer_irq)
    );

    always_comb begin
        csr_rdata = '0;
        csr_hit   = sel.cnt || sel.match;
        if (sel.cnt)        csr_rdata = count_q;
        else if (sel.match) csr_rdata = {{PAD_W{1'b0}}, match_q};
    end

    // R5: a new request only follows a cycle at or below the match value
    assert_rise_from_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq) |-> ($past(count_q[CMP_W-1:0]) <= $past(match_q)));

    // R7: a counter write never starts a request
    assert_no_fire_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_irq) |-> !$past(cnt_load));
endmodule

// File: tb/tb_insn_timer.sv
module tb_insn_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  retire_cnt = '0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_hit;
    logic        timer_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    insn_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_cnt (retire_cnt),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .csr_hit    (csr_hit),
        .timer_irq  (timer_irq)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: inputs applied after a falling edge, results seen at the next one
    task automatic cyc(logic [2:0] ret, logic we, logic [11:0] a, logic [63:0] d);
        retire_cnt = ret; csr_we = we; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        retire_cnt = '0; csr_we = 1'b0; csr_addr = 12'h000; csr_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] v, output logic h);
        csr_addr = a;
        #1;
        v = csr_rdata;
        h = csr_hit;
        csr_addr = 12'h000;
    endtask

    task automatic t_reset();
        logic [63:0] v; logic h;
        chk("R1 irq", {63'd0, timer_irq}, 64'd0);
        rd(12'hC00, v, h); chk("R1 count", v, 64'd0);
        rd(12'h7C1, v, h); chk("R1 match", v, 64'h0000_0000_FFFF_FFFF);
    endtask

    task automatic t_alias();
        logic [63:0] v; logic h;
        cyc(3'd0, 1'b1, 12'hC01, 64'd100);
        rd(12'hC00, v, h); chk("R3 cycle alias", v, 64'd100);
        rd(12'hC02, v, h); chk("R3 instret alias", v, 64'd100);
        rd(12'h7C0, v, h); chk("R3 count alias", v, 64'd100);
        chk("R3 hit", {63'd0, h}, 64'd1);
        cyc(3'd0, 1'b1, 12'h123, 64'd5);
        rd(12'h123, v, h);
        chk("R3 unknown rdata", v, 64'd0);
        chk("R3 unknown hit", {63'd0, h}, 64'd0);
        rd(12'hC00, v, h); chk("R3 unknown write ignored", v, 64'd100);
    endtask

    task automatic t_advance();
        logic [63:0] v; logic h;
        cyc(3'd3, 1'b0, 12'h000, 64'd0);
        rd(12'hC00, v, h); chk("R2 add 3", v, 64'd103);
        cyc(3'd7, 1'b0, 12'h000, 64'd0);
        rd(12'hC00, v, h); chk("R2 clamp 7 to 4", v, 64'd107);
    endtask

    task automatic t_priority();
        logic [63:0] v; logic h;
        cyc(3'd4, 1'b1, 12'hC02, 64'd50);
        rd(12'hC00, v, h); chk("R4 write wins", v, 64'd50);
    endtask

    task automatic t_cross_exact();
        cyc(3'd0, 1'b1, 12'h7C1, 64'd60);
        cyc(3'd4, 1'b0, 12'h000, 64'd0);   // 54
        cyc(3'd4, 1'b0, 12'h000, 64'd0);   // 58
        chk("R5 below, no request", {63'd0, timer_irq}, 64'd0);
        cyc(3'd2, 1'b0, 12'h000, 64'd0);   // 60
        chk("R5 exact reach", {63'd0, timer_irq}, 64'd1);
    endtask

    task automatic t_jump();
        cyc(3'd0, 1'b1, 12'h7C1, 64'd200);
        chk("R8 match write clears", {63'd0, timer_irq}, 64'd0);
        cyc(3'd0, 1'b1, 12'h7C0, 64'd197);
        cyc(3'd4, 1'b0, 12'h000, 64'd0);   // 201
        chk("R5 jump past", {63'd0, timer_irq}, 64'd1);
    endtask

    task automatic t_sticky();
        cyc(3'd0, 1'b1, 12'hC00, 64'd10);
        chk("R9 held after rewrite below", {63'd0, timer_irq}, 64'd1);
        cyc(3'd1, 1'b0, 12'h000, 64'd0);
        cyc(3'd0, 1'b0, 12'h000, 64'd0);
        chk("R9 still held", {63'd0, timer_irq}, 64'd1);
    endtask

    task automatic t_upper();
        logic [63:0] v; logic h;
        cyc(3'd0, 1'b1, 12'h7C1, 64'h20);
        chk("R8 clear again", {63'd0, timer_irq}, 64'd0);
        cyc(3'd0, 1'b1, 12'h7C0, 64'h5_0000_001E);
        cyc(3'd4, 1'b0, 12'h000, 64'd0);
        chk("R6 high bits ignored", {63'd0, timer_irq}, 64'd1);
        rd(12'hC01, v, h); chk("R6 count value", v, 64'h5_0000_0022);
    endtask

    task automatic t_no_wrap();
        cyc(3'd0, 1'b1, 12'h7C1, 64'd1);
        cyc(3'd0, 1'b1, 12'h7C0, 64'h0000_0000_FFFF_FFFE);
        cyc(3'd4, 1'b0, 12'h000, 64'd0);
        chk("R10 wrap silent", {63'd0, timer_irq}, 64'd0);
        cyc(3'd0, 1'b0, 12'h000, 64'd0);
        chk("R10 stays low", {63'd0, timer_irq}, 64'd0);
    endtask

    task automatic t_load_no_eval();
        cyc(3'd0, 1'b1, 12'h7C1, 64'd300);
        cyc(3'd0, 1'b1, 12'h7C0, 64'd299);
        cyc(3'd4, 1'b1, 12'h7C0, 64'd400);
        chk("R7 write cycle not evaluated", {63'd0, timer_irq}, 64'd0);
        cyc(3'd0, 1'b0, 12'h000, 64'd0);
        chk("R7 still low", {63'd0, timer_irq}, 64'd0);
    endtask

    task automatic t_match_priority();
        logic [63:0] v; logic h;
        cyc(3'd0, 1'b1, 12'h7C1, 64'd500);
        cyc(3'd0, 1'b1, 12'h7C0, 64'd498);
        retire_cnt = 3'd4; csr_we = 1'b1; csr_addr = 12'h7C1; csr_wdata = 64'd1000;
        @(negedge clk);
        retire_cnt = '0; csr_we = 1'b0; csr_addr = 12'h000; csr_wdata = '0;
        chk("R8 match write beats crossing", {63'd0, timer_irq}, 64'd0);
        rd(12'hC00, v, h); chk("R8 count advanced", v, 64'd502);
        rd(12'h7C1, v, h); chk("R8 match loaded", v, 64'd1000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alias();
        t_advance();
        t_priority();
        t_cross_exact();
        t_jump();
        t_sticky();
        t_upper();
        t_no_wrap();
        t_load_no_eval();
        t_match_priority();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule